// File: doc/BRIEF.md
# Extended-Precision ALU Flag Unit

This block is the arithmetic corner of an integer datapath that deals with multi-word quantities and with shifts that report the bits they push out. It performs two kinds of operation on a 32-bit operand pair. The first kind is add or subtract that folds in a stored extend bit. The second kind is shifting: left, logical right and arithmetic right. The result leaves the block in the same cycle the operands arrive. A five-bit flag register is updated on the next rising clock edge.

Multi-word add and subtract chain through the extend flag. The zero flag only ever clears during such a chain, so after the last word it tells whether the whole multi-word result was zero. Software can overwrite all five flags at once through a load port. A load in the same cycle as an operation wins over the operation. The register resets to all zeros.

Top module: `xalu_flags`

## Requirements
- R1: While reset is asserted and after it is released, `flags` reads 0 until the first load or operation.
- R2: The flag bit positions are X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. When `flag_load` is high, `flags` takes `flag_din` on the next edge, even if a valid operation is issued in the same cycle.
- R3: Opcode 0 (add-extend) gives `result` = a + b + X mod 2^32. Its carry out goes into both X and C, and N takes bit 31 of the result.
- R4: Opcode 1 (subtract-extend) gives `result` = a − b − X mod 2^32. Its borrow (set when a < b + X as unsigned numbers) goes into both X and C, and N takes bit 31 of the result.
- R5: For opcodes 0 and 1, a nonzero result clears Z and a zero result leaves Z as it was.
- R6: For opcode 0, V is set when a and b have the same sign and the result's sign differs from theirs. For opcode 1, V is set when a and b differ in sign and the result's sign differs from a's.
- R7: Shifts use only bits 5:0 of b as the count (0..63). Opcode 2 (shift left) and opcode 3 (logical shift right) give a zero result for counts of 32 or more. Opcode 4 (arithmetic shift right) fills with copies of the sign bit.
- R8: The shift C is the last bit shifted out. It is 0 for a count of 0 and 0 for left or logical-right counts above 32. For arithmetic-right counts above 32 it equals the sign bit.
- R9: A shift with a nonzero count copies C into X. A count of 0 leaves X unchanged.
- R10: Shifts set N from bit 31 of the result and Z when the result is zero. V is 0 for logical shifts. For the arithmetic shift, V is set when the result's sign differs from a's sign, which never happens.
- R11: Flags are unchanged when `op_valid` is low, or when the opcode is 5, 6 or 7. Those reserved opcodes drive `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid | input | 1 | Operation strobe; flags update on the next edge |
| op_code | input | 3 | Operation select (0 add-x, 1 sub-x, 2 shl, 3 shr, 4 sar) |
| opnd_a | input | 32 | First operand, or value to shift |
| opnd_b | input | 32 | Second operand, or shift count in bits 5:0 |
| flag_load | input | 1 | Write all five flags from `flag_din` |
| flag_din | input | 5 | Flag values to load {X,N,Z,V,C} |
| result | output | 32 | Combinational result |
| flags | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The carry rules depend on the stored X, so the hardest cases are the carry rules with X set and the sticky Z taken from both starting states. Ordinary operation sequences rarely reach these in a controlled way. Before every add or subtract, the stimulus uses the load port to preset X and Z in all four combinations, and then sweeps the operands over sign and range extremes. The shift count is swept from 0 to 63 with X preset both ways, so that the count-of-zero X hold and the counts around 32 are each hit directly.

// File: rtl/xalu_pkg.sv
`timescale 1ns/1ps
package xalu_pkg;

  typedef enum logic [2:0] {
    OP_ADDX = 3'd0,
    OP_SUBX = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_SAR  = 3'd4
  } xalu_op_e;

  // Bit order {X,N,Z,V,C}; X is the most significant.
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } xalu_flags_t;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RLOG  = 2'd1,
    SK_RARI  = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/xalu_arith.sv
`timescale 1ns/1ps
module xalu_arith #(
  parameter int WIDTH = 32
) (
  input  logic             sub_sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             x_in,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf,
  output logic             nonzero
);

  // Carry from a compare against the operands rather than a wide adder.
  function automatic logic ext_carry(input logic sub, input logic x,
                                     input logic [WIDTH-1:0] opa,
                                     input logic [WIDTH-1:0] opb,
                                     input logic [WIDTH-1:0] r);
    if (sub) return x ? (opa <= opb) : (opa < opb);
    else     return x ? (r <= opb)   : (r < opb);
  endfunction

  function automatic logic ext_ovf(input logic sub,
                                   input logic [WIDTH-1:0] opa,
                                   input logic [WIDTH-1:0] opb,
                                   input logic [WIDTH-1:0] r);
    logic [WIDTH-1:0] t;
    if (sub) t = (r ^ opa) & (opa ^ opb);
    else     t = (r ^ opa) & ~(opa ^ opb);
    return t[WIDTH-1];
  endfunction

  always_comb begin
    if (sub_sel) res = a - b - {{(WIDTH-1){1'b0}}, x_in};
    else         res = a + b + {{(WIDTH-1){1'b0}}, x_in};
    carry   = ext_carry(sub_sel, x_in, a, b, res);
    ovf     = ext_ovf(sub_sel, a, b, res);
    nonzero = |res;
  end

endmodule

// File: rtl/xalu_shift.sv
`timescale 1ns/1ps
module xalu_shift
  import xalu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input  shift_kind_e      kind,
  input  logic [WIDTH-1:0] a,
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf
);

  // One guard bit beside the word keeps the last bit shifted out.
  logic [WIDTH:0] lft;
  logic [WIDTH:0] rgt;

  always_comb begin
    lft = {1'b0, a} << cnt;
    if (kind == SK_RARI) rgt = $signed({a, 1'b0}) >>> cnt;
    else                 rgt = {a, 1'b0} >> cnt;
    if (kind == SK_LEFT) begin
      res  = lft[WIDTH-1:0];
      cout = lft[WIDTH];
    end else begin
      res  = rgt[WIDTH:1];
      cout = rgt[0];
    end
    ovf = (kind == SK_RARI) ? (res[WIDTH-1] ^ a[WIDTH-1]) : 1'b0;
  end

endmodule

// File: rtl/xalu_flagreg.sv
`timescale 1ns/1ps
module xalu_flagreg
  import xalu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  xalu_flags_t load_val,
  input  logic        upd,
  input  xalu_flags_t upd_val,
  output xalu_flags_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (upd)  q <= upd_val;
  end

endmodule

// File: rtl/xalu_flags.sv
`timescale 1ns/1ps
module xalu_flags
  import xalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             flag_load,
  input  logic [4:0]       flag_din,
  output logic [WIDTH-1:0] result,
  output logic [4:0]       flags
);

  localparam int CNT_W = $clog2(WIDTH) + 1;

  xalu_flags_t      cur_f;
  xalu_flags_t      nxt_f;
  xalu_flags_t      ld_f;
  logic             arith_sel;
  logic             sub_sel;
  logic             shift_sel;
  shift_kind_e      shift_kind;
  logic             upd_en;
  logic             cnt_nonzero;
  logic [CNT_W-1:0] shift_cnt;
  logic [WIDTH-1:0] ar_res;
  logic             ar_carry;
  logic             ar_ovf;
  logic             ar_nz;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cout;
  logic             sh_ovf;

  always_comb begin
    arith_sel  = 1'b0;
    shift_sel  = 1'b0;
    sub_sel    = 1'b0;
    shift_kind = SK_LEFT;
    unique case (op_code)
      OP_ADDX: arith_sel = 1'b1;
      OP_SUBX: begin arith_sel = 1'b1; sub_sel = 1'b1; end
      OP_SHL:  shift_sel = 1'b1;
      OP_SHR:  begin shift_sel = 1'b1; shift_kind = SK_RLOG; end
      OP_SAR:  begin shift_sel = 1'b1; shift_kind = SK_RARI; end
      default: ;
    endcase
  end

  assign shift_cnt   = opnd_b[CNT_W-1:0];
  assign cnt_nonzero = |shift_cnt;
  assign upd_en      = op_valid & (arith_sel | shift_sel);
  assign ld_f        = flag_din;

  xalu_arith #(.WIDTH(WIDTH)) u_arith (
    .sub_sel (sub_sel),
    .a       (opnd_a),
    .b       (opnd_b),
    .x_in    (cur_f.x),
    .res     (ar_res),
    .carry   (ar_carry),
    .ovf     (ar_ovf),
    .nonzero (ar_nz)
  );

  xalu_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
    .kind (shift_kind),
    .a    (opnd_a),
    .cnt  (shift_cnt),
    .res  (sh_res),
    .cout (sh_cout),
    .ovf  (sh_ovf)
  );

  always_comb begin
    nxt_f = cur_f;
    if (arith_sel) begin
      result  = ar_res;
      nxt_f.x = ar_carry;
      nxt_f.c = ar_carry;
      nxt_f.n = ar_res[WIDTH-1];
      nxt_f.z = cur_f.z & ~ar_nz;
      nxt_f.v = ar_ovf;
    end else if (shift_sel) begin
      result  = sh_res;
      nxt_f.x = cnt_nonzero ? sh_cout : cur_f.x;
      nxt_f.c = sh_cout;
      nxt_f.n = sh_res[WIDTH-1];
      nxt_f.z = ~|sh_res;
      nxt_f.v = sh_ovf;
    end else begin
      result = '0;
    end
  end

  xalu_flagreg u_freg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (flag_load),
    .load_val (ld_f),
    .upd      (upd_en),
    .upd_val  (nxt_f),
    .q        (cur_f)
  );

  assign flags = cur_f;

endmodule

// File: rtl/xalu_flags_chk.sv
`timescale 1ns/1ps
module xalu_flags_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [WIDTH-1:0] opnd_b,
  input logic             flag_load,
  input logic [4:0]       flag_din,
  input logic             upd_en,
  input logic [WIDTH-1:0] result,
  input logic [4:0]       flags
);

  localparam int CNT_W = $clog2(WIDTH) + 1;

  logic             is_arith;
  logic             is_shift;
  logic             is_logical;
  logic [CNT_W-1:0] cnt;

  assign is_arith   = op_valid && !flag_load && (op_code <= 3'd1);
  assign is_shift   = op_valid && !flag_load && (op_code >= 3'd2) && (op_code <= 3'd4);
  assign is_logical = op_valid && !flag_load && ((op_code == 3'd2) || (op_code == 3'd3));
  assign cnt        = opnd_b[CNT_W-1:0];

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> flags == $past(flag_din));

  p_x_tracks_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith |=> flags[4] == flags[0]);

  p_z_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith |=> !(flags[2] && !$past(flags[2])));

  p_wide_count_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_logical && (int'(cnt) >= WIDTH)) |-> result == '0);

  p_zero_count_keeps_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && (cnt == '0)) |=> flags[4] == $past(flags[4]));

  p_logical_v_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_logical |=> !flags[1]);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_load && !upd_en) |=> $stable(flags));

  p_reserved_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 3'd4) |-> result == '0);

endmodule

bind xalu_flags xalu_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .opnd_b    (opnd_b),
  .flag_load (flag_load),
  .flag_din  (flag_din),
  .upd_en    (upd_en),
  .result    (result),
  .flags     (flags)
);

// File: tb/xalu_flags_test.sv
`timescale 1ns/1ps
module xalu_flags_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        flag_load = 1'b0;
  logic [4:0]  flag_din = '0;
  logic [31:0] result;
  logic [4:0]  flags;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [4:0] m_flags = '0;

  always #2 clk = ~clk;

  xalu_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_load(flag_load),
    .flag_din(flag_din), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference computed from the requirement wording with wide arithmetic.
  task automatic model(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] f,
                       output logic [31:0] r, output logic [4:0] nf);
    logic [32:0] w;
    logic        c, ov;
    int          k;
    nf = f;
    r  = '0;
    k  = int'(b[5:0]);
    case (op)
      3'd0: begin
        w  = {1'b0, a} + {1'b0, b} + {32'b0, f[4]};
        r  = w[31:0];
        ov = (a[31] == b[31]) && (r[31] != a[31]);
        nf = {w[32], r[31], f[2] && (r == 0), ov, w[32]};
      end
      3'd1: begin
        w  = {1'b0, a} - {1'b0, b} - {32'b0, f[4]};
        r  = w[31:0];
        ov = (a[31] != b[31]) && (r[31] != a[31]);
        nf = {w[32], r[31], f[2] && (r == 0), ov, w[32]};
      end
      3'd2, 3'd3, 3'd4: begin
        if (op == 3'd2) begin
          r = (k >= 32) ? 32'h0 : (a << k);
          c = (k == 0 || k > 32) ? 1'b0 : a[32-k];
        end else if (op == 3'd3) begin
          r = (k >= 32) ? 32'h0 : (a >> k);
          c = (k == 0 || k > 32) ? 1'b0 : a[k-1];
        end else begin
          r = (k >= 32) ? {32{a[31]}} : 32'($signed(a) >>> k);
          c = (k == 0) ? 1'b0 : (k > 32) ? a[31] : a[k-1];
        end
        nf = {(k != 0) ? c : f[4], r[31], r == 0, 1'b0, c};
      end
      default: begin
        r  = '0;
        nf = f;
      end
    endcase
    if (!v) nf = f;
  endtask

  task automatic load_flags(input logic [4:0] val, input logic with_op);
    @(negedge clk);
    flag_load = 1'b1;
    flag_din  = val;
    op_valid  = with_op;
    op_code   = 3'd0;
    opnd_a    = 32'hffff_ffff;
    opnd_b    = 32'h1;
    @(posedge clk);
    #1;
    flag_load = 1'b0;
    op_valid  = 1'b0;
    m_flags   = val;
    chk(with_op ? "R2 load over op" : "R2 load", {27'b0, flags}, {27'b0, val});
  endtask

  task automatic run_op(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic chk_res, input string tag);
    logic [31:0] er;
    logic [4:0]  ef;
    model(v, op, a, b, m_flags, er, ef);
    @(negedge clk);
    op_valid = v;
    op_code  = op;
    opnd_a   = a;
    opnd_b   = b;
    #1;
    if (chk_res) chk({tag, " result"}, result, er);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    chk({tag, " flags"}, {27'b0, flags}, {27'b0, ef});
    m_flags = ef;
  endtask

  logic [31:0] avals [8] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                             32'hffff_ffff, 32'h1234_5678, 32'hffff_fffe, 32'h8000_0001};
  logic [31:0] svals [6] = '{32'h8000_0001, 32'h0000_0001, 32'hffff_ffff,
                             32'h7fff_fffe, 32'ha5a5_a5a5, 32'h0};

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags in reset", {27'b0, flags}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 flags after reset", {27'b0, flags}, 32'h0);

    // R2: load alone, and load winning over a valid add.
    load_flags(5'b10101, 1'b0);
    load_flags(5'b01010, 1'b1);
    load_flags(5'b00000, 1'b1);

    // R3 R4 R5 R6: operand sweep with X and Z preset both ways.
    for (int op = 0; op < 2; op++)
      for (int pre = 0; pre < 4; pre++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            load_flags({pre[1], 1'b0, pre[0], 2'b00}, 1'b0);
            run_op(1'b1, 3'(op), avals[i], avals[j], 1'b1,
                   (op == 0) ? "R3/R5/R6 addx" : "R4/R5/R6 subx");
          end

    // R5: multi-word chain keeps Z only when every word is zero.
    load_flags(5'b00100, 1'b0);
    run_op(1'b1, 3'd0, 32'h0, 32'h0, 1'b1, "R5 chain word0");
    run_op(1'b1, 3'd0, 32'h0, 32'h0, 1'b1, "R5 chain word1");
    run_op(1'b1, 3'd0, 32'h1, 32'h0, 1'b1, "R5 chain word2");
    run_op(1'b1, 3'd0, 32'h0, 32'h0, 1'b1, "R5 chain word3");

    // R7 R8 R9 R10: every count for every shift kind, X preset both ways.
    for (int op = 2; op < 5; op++)
      for (int px = 0; px < 2; px++)
        for (int i = 0; i < 6; i++)
          for (int k = 0; k < 64; k++) begin
            if (k == 0) load_flags({px[0], 4'b0000}, 1'b0);
            run_op(1'b1, 3'(op), svals[i], 32'(k), 1'b1, "R7/R8/R9/R10 shift");
          end

    // R7: upper count bits ignored.
    run_op(1'b1, 3'd2, 32'h0000_0003, 32'h0000_0041, 1'b1, "R7 mask shl 65");
    run_op(1'b1, 3'd3, 32'h8000_0000, 32'hffff_ffdf, 1'b1, "R7 mask shr 31");
    run_op(1'b1, 3'd4, 32'h8000_0000, 32'h0000_0060, 1'b1, "R7 mask sar 32");

    // R9: zero count keeps a set X.
    load_flags(5'b10000, 1'b0);
    run_op(1'b1, 3'd3, 32'hffff_ffff, 32'h0000_0040, 1'b1, "R9 zero count x");

    // R11: no update when idle or reserved.
    load_flags(5'b11011, 1'b0);
    run_op(1'b0, 3'd0, 32'h1, 32'h1, 1'b0, "R11 op_valid low");
    run_op(1'b0, 3'd2, 32'h1, 32'h1, 1'b0, "R11 op_valid low shift");
    for (int op = 5; op < 8; op++)
      run_op(1'b1, 3'(op), 32'hdead_beef, 32'h3, 1'b1, "R11 reserved opcode");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule